// File: doc/BRIEF.md
# Low-Power Wake Sequencer

This block brings a processor back from its idle and sleep states to the running state. Software asks for a low-power state by pulsing an entry strobe with the target state. The block then holds and reports that state until one of two things happens. The first is a wake event: an interrupt source whose flag and individual enable are both set, or a watchdog wake pulse. The second is a reset request, which returns the block to run straight away and gives no resume strobe.

On a wake, the block first decides whether the primary oscillator has to be allowed to start up. While it does, the block waits for the oscillator-ready input. It then counts a fixed CPU settle delay. In the first cycle after that delay it emits a one-cycle resume strobe and reports run mode again. Together with the strobe, a vector flag tells the CPU to branch to the interrupt vector. The flag is raised only when an interrupt caused the wake and the global interrupt enable was set at that time. A watchdog wake never raises it.

Top module: `wake_seq`

## Requirements
- R1: After reset, mode_o reads 0 (run), and resume_o and vector_o are 0.
- R2: The mode encoding is 0 run, 1 primary-clock idle, 2 alternate-clock idle, 3 sleep. A pm_enter_i pulse while in run with a nonzero pm_mode_i shows that mode on mode_o from the next cycle. An entry pulse with pm_mode_i 0 is ignored, and so is an entry pulse while not in run.
- R3: In idle or sleep, an interrupt source i starts a wake only while both irq_flag_i[i] and irq_en_i[i] are 1. A flagged source whose enable is clear leaves mode_o unchanged and gives no resume_o.
- R4: vector_o is high only together with resume_o. It is 1 when an enabled interrupt was part of the wake and gie_i was 1 in the cycle the wake was sampled, and 0 otherwise.
- R5: A wdt_wake_i pulse in idle or sleep produces a normal wake to run (resume_o pulse, mode_o 0) with vector_o 0.
- R6: Without an oscillator wait, resume_o rises exactly TCSD_CYCLES clock edges after the edge that samples the wake. It lasts one cycle, and mode_o reads 0 from that cycle on.
- R7: A wake from primary-clock idle (mode 1) never waits for osc_rdy_i, whatever osc_type_i is.
- R8: The oscillator-type encoding is 0 crystal, 1 crystal with PLL, 2 RC or external clock, 3 internal. With type 2 or 3, no wake waits for osc_rdy_i.
- R9: With type 0 or 1, a wake from mode 2 or 3 holds resume_o low until osc_rdy_i is sampled high. resume_o then rises TCSD_CYCLES edges after that sample.
- R10: Interrupt and watchdog wake events that arrive while in run have no effect: resume_o stays 0.
- R11: rst_req_i returns the block to run on the next cycle from any state, with no resume_o pulse and with any wake in progress abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_flag_i | input | NUM_SRC | Per-source interrupt flags |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable, sampled at the wake |
| wdt_wake_i | input | 1 | Watchdog time-out pulse |
| rst_req_i | input | 1 | Synchronous reset request |
| pm_enter_i | input | 1 | Low-power entry strobe |
| pm_mode_i | input | 2 | Target mode for the entry strobe |
| osc_type_i | input | 2 | Primary oscillator type |
| osc_rdy_i | input | 1 | Primary oscillator ready |
| resume_o | output | 1 | One-cycle CPU resume strobe |
| vector_o | output | 1 | Branch to the interrupt vector (valid with resume_o) |
| mode_o | output | 2 | Current mode |

## Verification
The assertions look only at ports. They assume that rst_req_i is the only way back to run other than a completed wake. They also assume that the pm_mode_i value presented with an entry strobe is a legal code, and the 2-bit port leaves no other value possible. The oscillator wait is decided from osc_type_i at the wake, so the stimulus holds osc_type_i constant from entry until resume. The stimulus also raises osc_rdy_i only after it has checked the held-off interval. Wake inputs are released in the resume cycle so that a new wake never overlaps a finished one.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    PM_RUN      = 2'd0,
    PM_IDLE_PRI = 2'd1,
    PM_IDLE_ALT = 2'd2,
    PM_SLEEP    = 2'd3
  } pm_mode_e;

  typedef enum logic [1:0] {
    OSC_XTAL = 2'd0,
    OSC_PLL  = 2'd1,
    OSC_RC   = 2'd2,
    OSC_INT  = 2'd3
  } osc_kind_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_LOW    = 2'd1,
    ST_OST    = 2'd2,
    ST_SETTLE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/wake_src_detect.sv
module wake_src_detect #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               wdt_i,
  output logic               irq_hit_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = flag_i[g] & en_i[g];
  end

  assign irq_hit_o = |hit;
  assign wake_o    = irq_hit_o | wdt_i;
endmodule

// File: rtl/wake_ost_gate.sv
module wake_ost_gate
  import wake_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] osc_i,
  output logic       ost_req_o
);
  pm_mode_e  mode;
  osc_kind_e osc;
  logic      osc_slow_start;

  assign mode = pm_mode_e'(mode_i);
  assign osc  = osc_kind_e'(osc_i);

  // crystal-based sources need a start-up wait; RC, external and internal do not
  assign osc_slow_start = (osc == OSC_XTAL) || (osc == OSC_PLL);
  // primary clock keeps running in primary idle
  assign ost_req_o = osc_slow_start && (mode != PM_IDLE_PRI) && (mode != PM_RUN);
endmodule

// File: rtl/wake_settle_cnt.sv
module wake_settle_cnt #(
  parameter int TCSD_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (TCSD_CYCLES < 2) ? 1 : $clog2(TCSD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TCSD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int TCSD_CYCLES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_flag_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               gie_i,
  input  logic               wdt_wake_i,
  input  logic               rst_req_i,
  input  logic               pm_enter_i,
  input  logic [1:0]         pm_mode_i,
  input  logic [1:0]         osc_type_i,
  input  logic               osc_rdy_i,
  output logic               resume_o,
  output logic               vector_o,
  output logic [1:0]         mode_o
);
  seq_st_e    st_q, st_d;
  pm_mode_e   mode_q, mode_d;
  logic       vec_q, vec_d;
  logic       resume_q, resume_d;
  logic       irq_hit, wake, ost_req, settle_done;

  wake_src_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .flag_i    (irq_flag_i),
    .en_i      (irq_en_i),
    .wdt_i     (wdt_wake_i),
    .irq_hit_o (irq_hit),
    .wake_o    (wake)
  );

  wake_ost_gate u_ost (
    .mode_i    (mode_q),
    .osc_i     (osc_type_i),
    .ost_req_o (ost_req)
  );

  wake_settle_cnt #(.TCSD_CYCLES(TCSD_CYCLES)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (st_q != ST_SETTLE),
    .en_i    (st_q == ST_SETTLE),
    .done_o  (settle_done)
  );

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    vec_d    = vec_q;
    resume_d = 1'b0;
    if (rst_req_i) begin
      st_d   = ST_RUN;
      mode_d = PM_RUN;
      vec_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (pm_enter_i && (pm_mode_e'(pm_mode_i) != PM_RUN)) begin
            st_d   = ST_LOW;
            mode_d = pm_mode_e'(pm_mode_i);
          end
        end
        ST_LOW: begin
          if (wake) begin
            vec_d = irq_hit && gie_i;
            st_d  = ost_req ? ST_OST : ST_SETTLE;
          end
        end
        ST_OST: begin
          if (osc_rdy_i) st_d = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_done) begin
            st_d     = ST_RUN;
            mode_d   = PM_RUN;
            resume_d = 1'b1;
          end
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RUN;
      mode_q   <= PM_RUN;
      vec_q    <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_d;
      vec_q    <= vec_d;
      resume_q <= resume_d;
    end
  end

  assign resume_o = resume_q;
  assign vector_o = resume_q & vec_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rst_req_i,
  input logic       pm_enter_i,
  input logic [1:0] pm_mode_i,
  input logic       resume_o,
  input logic       vector_o,
  input logic [1:0] mode_o
);
  a_r6_resume_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  a_r6_resume_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (mode_o == 2'd0));

  a_r4_vector_needs_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> resume_o);

  a_r10_run_no_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !resume_o) |=> !resume_o);

  a_r11_reset_req_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (mode_o == 2'd0 && !resume_o));

  a_r2_enter_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && pm_enter_i && pm_mode_i != 2'd0 && !rst_req_i)
      |=> (mode_o == $past(pm_mode_i)));

  a_r2_low_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0 && !rst_req_i) |=> (resume_o || $stable(mode_o)));
endmodule

bind wake_seq wake_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_req_i  (rst_req_i),
  .pm_enter_i (pm_enter_i),
  .pm_mode_i  (pm_mode_i),
  .resume_o   (resume_o),
  .vector_o   (vector_o),
  .mode_o     (mode_o)
);

// File: tb/wake_seq_tb.sv
`timescale 1ns/1ps
module wake_seq_tb;
  localparam int NS = 8;
  localparam int T  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] flag = '0, en = '0;
  logic          gie = 1'b0, wdt = 1'b0, rreq = 1'b0, enter = 1'b0, rdy = 1'b0;
  logic [1:0]    pmode = 2'd0, osc = 2'd0;
  logic          resume, vec;
  logic [1:0]    mode;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  wake_seq #(.NUM_SRC(NS), .TCSD_CYCLES(T)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_flag_i(flag), .irq_en_i(en), .gie_i(gie),
    .wdt_wake_i(wdt), .rst_req_i(rreq), .pm_enter_i(enter), .pm_mode_i(pmode),
    .osc_type_i(osc), .osc_rdy_i(rdy), .resume_o(resume), .vector_o(vec), .mode_o(mode)
  );

  // reference model: phase 0 run, 1 low power, 2 oscillator wait, 3 settling
  int m_phase = 0, m_mode = 0, m_left = 0;
  bit m_res = 0, m_vec = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_mode <= 0; m_res <= 0; m_vec <= 0; m_left <= 0;
    end else begin
      m_res <= 0;
      if (rreq) begin
        m_phase <= 0; m_mode <= 0; m_vec <= 0;
      end else if (m_phase == 0) begin
        if (enter && pmode != 0) begin m_phase <= 1; m_mode <= pmode; end
      end else if (m_phase == 1) begin
        if ((flag & en) != 0 || wdt) begin
          m_vec <= ((flag & en) != 0) && gie;
          m_left <= T;
          m_phase <= (m_mode != 1 && osc < 2) ? 2 : 3;
        end
      end else if (m_phase == 2) begin
        if (rdy) m_phase <= 3;
      end else begin
        if (m_left == 1) begin m_phase <= 0; m_mode <= 0; m_res <= 1; end
        m_left <= m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (resume !== m_res || vec !== (m_res & m_vec) || mode !== 2'(m_mode)) begin
      n_bad++;
      $display("FAIL %s cycle compare: resume=%0b vector=%0b mode=%0d expected %0b %0b %0d",
               cur_req, resume, vec, mode, m_res, m_res & m_vec, m_mode);
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drv_edge();
    @(posedge clk); #2;
  endtask

  task automatic enter_mode(input logic [1:0] m);
    drv_edge(); enter = 1; pmode = m;
    drv_edge(); enter = 0; pmode = 0;
  endtask

  task automatic clear_wake();
    flag = '0; en = '0; wdt = 0;
  endtask

  // edges after the sampling edge until resume; returns -1 on timeout
  task automatic wait_resume(output int n);
    n = 0;
    @(posedge clk);
    for (int k = 1; k <= 60; k++) begin
      @(posedge clk); @(negedge clk);
      if (resume) begin n = k; clear_wake(); return; end
    end
    n = -1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", mode, 0, "reset mode"); chk("R1", resume, 0, "reset resume"); chk("R1", vec, 0, "reset vector");
    rst_n = 1;

    // R10: wakes in run are ignored
    cur_req = "R10";
    drv_edge(); flag = 8'h01; en = 8'h01; wdt = 1;
    repeat (6) begin @(negedge clk); chk("R10", resume, 0, "resume in run"); end
    drv_edge(); clear_wake();

    // R2: entry with mode 0 ignored
    cur_req = "R2";
    enter_mode(2'd0); @(negedge clk); chk("R2", mode, 0, "entry to run ignored");
    osc = 2'd2;
    enter_mode(2'd3); @(negedge clk); chk("R2", mode, 3, "enter sleep");
    enter_mode(2'd1); @(negedge clk); chk("R2", mode, 3, "entry while asleep ignored");

    // R3: flagged but disabled source does nothing, then enabled one wakes (R6, R4)
    cur_req = "R3";
    drv_edge(); flag = 8'h24; en = 8'h80; gie = 1;
    repeat (6) begin @(negedge clk); chk("R3", mode, 3, "disabled source no wake"); end
    cur_req = "R6";
    drv_edge(); en = 8'h84;
    wait_resume(lat); chk("R6", lat, T, "settle latency sleep RC");
    chk("R4", vec, 1, "vector with gie");
    @(negedge clk); chk("R6", resume, 0, "single pulse");

    // R4: gie clear -> no vector
    cur_req = "R4";
    osc = 2'd3; enter_mode(2'd2);
    drv_edge(); gie = 0; flag = 8'h10; en = 8'h10;
    wait_resume(lat); chk("R8", lat, T, "internal osc no wait");
    chk("R4", vec, 0, "vector without gie");

    // R5: watchdog wake, gie set but no vector
    cur_req = "R5";
    enter_mode(2'd3);
    drv_edge(); gie = 1; wdt = 1;
    wait_resume(lat); chk("R5", lat, T, "wdt wake latency");
    chk("R5", vec, 0, "wdt vector");
    chk("R5", mode, 0, "wdt to run");

    // R7: primary idle with crystal never waits
    cur_req = "R7";
    osc = 2'd0; rdy = 0; enter_mode(2'd1);
    drv_edge(); flag = 8'h02; en = 8'h02;
    wait_resume(lat); chk("R7", lat, T, "primary idle crystal latency");

    // R9: sleep with PLL crystal waits for ready
    cur_req = "R9";
    osc = 2'd1; enter_mode(2'd3);
    drv_edge(); wdt = 1;
    drv_edge(); wdt = 0;
    repeat (12) begin @(negedge clk); chk("R9", resume, 0, "held for oscillator"); end
    chk("R9", mode, 3, "still asleep during wait");
    drv_edge(); rdy = 1;
    wait_resume(lat); chk("R9", lat, T, "latency after ready");
    drv_edge(); rdy = 0;

    // R9: alternate idle with crystal also waits
    osc = 2'd0; enter_mode(2'd2);
    drv_edge(); flag = 8'h40; en = 8'h40;
    repeat (8) begin @(negedge clk); chk("R9", resume, 0, "alt idle held"); end
    drv_edge(); clear_wake(); rdy = 1;
    wait_resume(lat); chk("R9", lat, T, "alt idle after ready");
    drv_edge(); rdy = 0;

    // R11: reset request while asleep and mid-settle
    cur_req = "R11";
    osc = 2'd2; enter_mode(2'd3);
    drv_edge(); rreq = 1;
    drv_edge(); rreq = 0;
    @(negedge clk); chk("R11", mode, 0, "reset req from sleep");
    enter_mode(2'd3);
    drv_edge(); flag = 8'h01; en = 8'h01;
    drv_edge(); clear_wake();
    drv_edge(); rreq = 1;
    drv_edge(); rreq = 0;
    repeat (8) begin @(negedge clk); chk("R11", resume, 0, "abandoned settle"); end
    chk("R11", mode, 0, "run after abandon");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule